// File: doc/BRIEF.md
# Pin-Group Direction and Window Gating

This block decides, for each of 32 tester channels, whether the channel drives the device pin, returns data toward the pattern board, or switches between the two at run time. The channels are grouped into eight nibbles of four. Each nibble has a registered mode: fixed driver, fixed receiver or bidirectional. A bidirectional nibble takes its direction from one of four steering signals. These signals carry the pattern data of the last nibble, channels 28 to 31. Steering signal k governs nibbles 2k and 2k+1, and the highest signal governs only nibble 6.

A per-nibble window check works on the two comparator results of every channel. When it is enabled and the pin level lies strictly inside the band, the return path of that channel is disabled, which signals a mid-band level to the pattern board. Configuration is written one byte at a time through a simple write strobe. Every output is combinational from the registered configuration and the live channel inputs. An illegal setup is reported on a flag, and a defined fallback applies.

Top module: `pin_dir_gate`

## Requirements
- R1: After reset every nibble is a receiver and window checking is off, so pin_drv_en is all zeros, ret_drv_en is all ones and config_error is 0.
- R2: A write with wr_en high takes effect at the next clock edge. wr_sel 0 loads nibbles 0 to 3 and wr_sel 1 loads nibbles 4 to 7. In those bytes, bit j of [3:0] is the fixed-driver bit of the j-th nibble of the byte, and bit j of [7:4] is its bidirectional bit. wr_sel 2 loads the window enables, with bit n belonging to nibble n. A write with wr_sel 3 changes nothing.
- R3: A nibble whose bidirectional bit is 0 and whose fixed-driver bit is 1 drives on all four channels (pin_drv_en 1, ret_drv_en 0), whatever the steering signals and comparators do.
- R4: A nibble with both bits 0 is a receiver: pin_drv_en 0 and ret_drv_en 1, subject to R7.
- R5: A nibble 0 to 6 whose bidirectional bit is 1 is bidirectional, whatever its fixed-driver bit. When its steering signal is 1, pin_drv_en is 1 and ret_drv_en is 0. When the steering signal is 0, pin_drv_en is 0 and ret_drv_en is 1, subject to R7.
- R6: Nibble n (0 to 6) is steered by dir_ctrl[n/2]: dir_ctrl[0] steers channels 0 to 7, dir_ctrl[1] channels 8 to 15, dir_ctrl[2] channels 16 to 23, and dir_ctrl[3] channels 24 to 27 only.
- R7: cmp_lo[c]=1 means that channel c is above the low threshold, and cmp_hi[c]=1 means that it is above the high threshold. When the window enable of c's nibble is 1, cmp_lo[c] is 1 and cmp_hi[c] is 0, ret_drv_en[c] is 0. With the enable at 0 the comparators have no effect.
- R8: If the bidirectional bit of nibble 7 is set, nibble 7 behaves as a receiver and config_error is 1.
- R9: If any of nibbles 0 to 6 is bidirectional while nibble 7 is not a fixed driver, config_error is 1. Otherwise, when R8 does not apply, config_error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Selects the configuration byte being written |
| wr_data | input | 8 | Configuration byte value |
| dir_ctrl | input | 4 | Steering signals (pattern data of channels 28 to 31) |
| cmp_hi | input | 32 | Per-channel result of the high-threshold comparator |
| cmp_lo | input | 32 | Per-channel result of the low-threshold comparator |
| pin_drv_en | output | 32 | Per-channel enable of the driver toward the device pin |
| ret_drv_en | output | 32 | Per-channel enable of the return driver toward the pattern board |
| config_error | output | 1 | Illegal direction setup present |

## Verification
The assertions assume that the comparator pair of a channel is consistent with a single level. This means that cmp_hi set together with cmp_lo clear never occurs. They also assume that wr_sel and wr_data are stable around the clock edge while wr_en is high. The stimulus drives every input half a cycle away from the capturing edge. Its random comparator patterns are built from a per-channel level class of below, inside or above the band, so the impossible pair never appears. Directed phases cover every steering pattern, both illegal setups of the last nibble, and a write to the unused selector.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [1:0] {
        MODE_RX = 2'd0,
        MODE_TX = 2'd1,
        MODE_BI = 2'd2
    } nib_mode_e;

    // Bidirectional wins over fixed driver; a nibble that may not be
    // bidirectional falls back to receiver when its bidirectional bit is set.
    function automatic nib_mode_e resolve_mode(input logic fix_bit,
                                               input logic bid_bit,
                                               input logic allow_bi);
        if (bid_bit && allow_bi) return MODE_BI;
        if (bid_bit)             return MODE_RX;
        if (fix_bit)             return MODE_TX;
        return MODE_RX;
    endfunction

endpackage

// File: rtl/pdg_cfg_regs.sv
module pdg_cfg_regs #(
    parameter int NIBBLES = 8,
    parameter int BYTE_W  = 8,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [NIBBLES-1:0] fix_q,
    output logic [NIBBLES-1:0] bid_q,
    output logic [NIBBLES-1:0] det_q
);
    localparam int NPB        = BYTE_W / 2;
    localparam int CTRL_BYTES = NIBBLES / NPB;

    typedef struct packed {
        logic [NIBBLES-1:0] fix;
        logic [NIBBLES-1:0] bid;
        logic [NIBBLES-1:0] det;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int b = 0; b < CTRL_BYTES; b++) begin
                if (wr_sel == SEL_W'(b)) begin
                    cfg_d.fix[b*NPB +: NPB] = wr_data[NPB-1:0];
                    cfg_d.bid[b*NPB +: NPB] = wr_data[BYTE_W-1:NPB];
                end
            end
            if (wr_sel == SEL_W'(CTRL_BYTES)) begin
                cfg_d.det = wr_data[NIBBLES-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign fix_q = cfg_q.fix;
    assign bid_q = cfg_q.bid;
    assign det_q = cfg_q.det;

    // R1: configuration is cleared when reset releases
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fix_q == '0 && bid_q == '0 && det_q == '0));

    // R2: a write to byte 0 lands in the low nibble fields one edge later
    p_wr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=>
        (fix_q[NPB-1:0] == $past(wr_data[NPB-1:0]) &&
         bid_q[NPB-1:0] == $past(wr_data[BYTE_W-1:NPB])));

    // R2: unused selector values and idle cycles leave the configuration alone
    p_wr_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel > SEL_W'(CTRL_BYTES)) |=>
        ($stable(fix_q) && $stable(bid_q) && $stable(det_q)));

endmodule

// File: rtl/pdg_nibble.sv
module pdg_nibble
    import pdg_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int ALLOW_BI = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fix_bit,
    input  logic             bid_bit,
    input  logic             det_bit,
    input  logic             dir_bit,
    input  logic [NIB_W-1:0] cmp_hi,
    input  logic [NIB_W-1:0] cmp_lo,
    output logic [NIB_W-1:0] drv_en,
    output logic [NIB_W-1:0] ret_en
);
    nib_mode_e        mode;
    logic [NIB_W-1:0] mid_band;

    always_comb begin
        mode     = resolve_mode(fix_bit, bid_bit, ALLOW_BI != 0);
        mid_band = cmp_lo & ~cmp_hi & {NIB_W{det_bit}};
        case (mode)
            MODE_TX: begin
                drv_en = '1;
                ret_en = '0;
            end
            MODE_BI: begin
                drv_en = {NIB_W{dir_bit}};
                ret_en = {NIB_W{~dir_bit}} & ~mid_band;
            end
            default: begin
                drv_en = '0;
                ret_en = ~mid_band;
            end
        endcase
    end

    // R3: a fixed driver nibble always drives and never returns
    p_fixed_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_bit && !bid_bit) |-> (drv_en == '1 && ret_en == '0));

    // R5: no channel drives and returns at once
    p_excl_paths_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_en & ret_en) == '0));

    // R5: a high steering signal makes a bidirectional nibble drive
    p_bidir_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bid_bit && ALLOW_BI != 0 && dir_bit) |-> (drv_en == '1));

    // R7: an enabled window blocks the return path on mid-band levels
    p_window_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        det_bit |-> ((cmp_lo & ~cmp_hi & ret_en) == '0));

    // R8: the steering nibble never drives when set bidirectional
    p_last_no_bidir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bid_bit && ALLOW_BI == 0) |-> (drv_en == '0));

endmodule

// File: rtl/pin_dir_gate.sv
module pin_dir_gate #(
    parameter int NIBBLES  = 8,
    parameter int NIB_W    = 4,
    parameter int GRP_NIBS = 2,
    parameter int BYTE_W   = 8,
    parameter int SEL_W    = 2,
    localparam int CH      = NIBBLES * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [NIB_W-1:0]  dir_ctrl,
    input  logic [CH-1:0]     cmp_hi,
    input  logic [CH-1:0]     cmp_lo,
    output logic [CH-1:0]     pin_drv_en,
    output logic [CH-1:0]     ret_drv_en,
    output logic              config_error
);
    localparam int LASTN = NIBBLES - 1;

    logic [NIBBLES-1:0] fix_q, bid_q, det_q;

    pdg_cfg_regs #(
        .NIBBLES (NIBBLES),
        .BYTE_W  (BYTE_W),
        .SEL_W   (SEL_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .fix_q   (fix_q),
        .bid_q   (bid_q),
        .det_q   (det_q)
    );

    for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
        pdg_nibble #(
            .NIB_W    (NIB_W),
            .ALLOW_BI ((n == LASTN) ? 0 : 1)
        ) nib_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .fix_bit (fix_q[n]),
            .bid_bit (bid_q[n]),
            .det_bit (det_q[n]),
            .dir_bit (dir_ctrl[n / GRP_NIBS]),
            .cmp_hi  (cmp_hi[n*NIB_W +: NIB_W]),
            .cmp_lo  (cmp_lo[n*NIB_W +: NIB_W]),
            .drv_en  (pin_drv_en[n*NIB_W +: NIB_W]),
            .ret_en  (ret_drv_en[n*NIB_W +: NIB_W])
        );
    end

    always_comb begin
        config_error = bid_q[LASTN] | ((|bid_q[LASTN-1:0]) & ~fix_q[LASTN]);
    end

    // R8: bidirectional bit on the steering nibble is flagged
    p_err_last_bidir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bid_q[LASTN] |-> config_error);

    // R9: a bidirectional group without a driving steering nibble is flagged
    p_err_no_steer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bid_q[LASTN-1:0]) && !fix_q[LASTN]) |-> config_error);

endmodule

// File: tb/pin_dir_gate_tb.sv
module pin_dir_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  dir_ctrl = '0;
    logic [31:0] cmp_hi = '0;
    logic [31:0] cmp_lo = '0;
    logic [31:0] pin_drv_en, ret_drv_en;
    logic        config_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit chk_on   = 1'b0;
    bit m_wrote  = 1'b0;
    bit [7:0] m_fix = '0, m_bid = '0, m_det = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_dir_gate dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dir_ctrl(dir_ctrl), .cmp_hi(cmp_hi),
        .cmp_lo(cmp_lo), .pin_drv_en(pin_drv_en), .ret_drv_en(ret_drv_en),
        .config_error(config_error)
    );

    // Reference model of the configuration bytes (R2)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_fix = '0; m_bid = '0; m_det = '0; m_wrote = 1'b0;
        end else begin
            m_wrote = wr_en;
            if (wr_en) begin
                if (wr_sel == 2'd0) begin
                    for (int j = 0; j < 4; j++) begin
                        m_fix[j] = wr_data[j]; m_bid[j] = wr_data[j+4];
                    end
                end else if (wr_sel == 2'd1) begin
                    for (int j = 0; j < 4; j++) begin
                        m_fix[j+4] = wr_data[j]; m_bid[j+4] = wr_data[j+4];
                    end
                end else if (wr_sel == 2'd2) begin
                    m_det = wr_data;
                end
            end
        end
    end

    task automatic compare_all(input string forced_tag);
        bit exp_d, exp_r, exp_e, any_bi;
        string tag;
        int bad;
        bad = 0;
        for (int c = 0; c < 32; c++) begin
            int nib;
            bit steer, win;
            nib   = c / 4;
            steer = dir_ctrl[nib / 2];
            win   = m_det[nib] && cmp_lo[c] && !cmp_hi[c];
            if (nib == 7 && m_bid[nib]) begin
                exp_d = 0; exp_r = !win; tag = "R8";
            end else if (m_bid[nib]) begin
                exp_d = steer; exp_r = !steer && !win; tag = "R5/R6";
            end else if (m_fix[nib]) begin
                exp_d = 1; exp_r = 0; tag = "R3";
            end else begin
                exp_d = 0; exp_r = !win; tag = "R4";
            end
            if (win && tag != "R3") tag = {tag, "/R7"};
            if (m_wrote) tag = {tag, "/R2"};
            if (forced_tag != "") tag = forced_tag;
            if (bad == 0 && (pin_drv_en[c] !== exp_d || ret_drv_en[c] !== exp_r)) begin
                bad = 1;
                $display("FAIL %s ch%0d: drv=%b exp %b ret=%b exp %b", tag, c,
                         pin_drv_en[c], exp_d, ret_drv_en[c], exp_r);
            end
        end
        n_checks++;
        if (bad != 0) n_fail++;
        any_bi = |m_bid[6:0];
        exp_e  = m_bid[7] || (any_bi && !m_fix[7]);
        n_checks++;
        if (config_error !== exp_e) begin
            n_fail++;
            $display("FAIL %s config_error=%b exp %b",
                     (forced_tag != "") ? forced_tag : (m_bid[7] ? "R8" : "R9"),
                     config_error, exp_e);
        end
    endtask

    // Compare on every clock, on the falling edge where nothing changes
    always @(negedge clk) begin
        if (rst_n && chk_on) compare_all("");
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        cyc(1);
        wr_en = 1'b0;
    endtask

    // Comparator pair from a consistent level class: 0 below, 1 inside, 2 above
    task automatic rand_levels();
        for (int c = 0; c < 32; c++) begin
            int k;
            k = $urandom_range(0, 2);
            cmp_lo[c] = (k != 0);
            cmp_hi[c] = (k == 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        cmp_lo = 32'hFFFF_FFFF; cmp_hi = '0;
        rst_n = 1'b1;
        #1;
        compare_all("R1");   // reset state with mid-band levels present
        chk_on = 1'b1;
        cyc(1);
        wr(2'd0, 8'h0F);     // R3: nibbles 0-3 fixed drivers
        cyc(2);
        wr(2'd1, 8'h70);     // R9: bidir 4-6, steering nibble receiver
        for (int p = 0; p < 16; p++) begin
            dir_ctrl = 4'(p); cyc(1);
        end
        wr(2'd1, 8'h78);     // R9 cleared: steering nibble drives
        wr(2'd0, 8'hF5);     // R5: bidir wins over fixed bit; R6 across patterns
        for (int p = 0; p < 16; p++) begin
            dir_ctrl = 4'(p); cyc(1);
        end
        wr(2'd1, 8'h80);     // R8: steering nibble set bidirectional
        cyc(2);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hA5);     // R7: window on some nibbles
        for (int i = 0; i < 20; i++) begin
            rand_levels(); cyc(1);
        end
        wr(2'd3, 8'hFF);     // R2: unused selector ignored
        cyc(2);
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                wr_en = 1'b1; wr_sel = 2'($urandom); wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            dir_ctrl = 4'($urandom);
            rand_levels();
            cyc(1);
        end
        wr_en = 1'b0;
        cyc(2);
        chk_on = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule